// File: doc/BRIEF.md
# Scheduled Periodic Pin Output

This block drives one timing pin from a free-running time counter. Software loads a 64-bit start time and a 32-bit half-period, measured in counter ticks, and then issues a start strobe. The pin stays low until the counter reaches the start time. At that point it goes high, and from then on it toggles every half-period. The result is a square wave with a 50% duty cycle, phase-locked to the counter. A stop strobe halts the wave and returns the pin to low.

The same pin can be turned around into a capture input. In capture mode the block releases the pin driver and passes the incoming level through a synchronizer. On every rising or falling edge it copies the current counter value into a single timestamp register. The register holds only the most recent capture, so a newer edge replaces the older value.

Top module: `sched_pin_wave`

## Requirements
- R1: After reset, `pin_out` is 0, `sync_ts` is 0 and, with `capture_mode` low, `pin_oe` is 1.
- R2: A start strobe is ignored when `start_time` is less than or equal to the `time_now` value sampled on the same clock edge. The pin then stays low.
- R3: A start strobe is ignored when `half_per` is 0. The pin stays low even after the requested start time has passed.
- R4: After a valid start, `pin_out` stays low until the first clock edge at which `time_now >= start_time`. It goes high on that edge.
- R5: Edge k (k = 0, 1, 2, ...) occurs on the first clock edge at which `time_now >= start_time + k*half_per`, and each edge inverts the pin. The schedule is built by adding the half-period to the previous scheduled edge time, so edges do not drift. A half-period of 1 toggles the pin on every tick.
- R6: A stop strobe returns `pin_out` to 0 on the next edge and halts the wave. When start and stop arrive together, stop wins.
- R7: While `capture_mode` is 1, `pin_oe` is 0, `pin_out` is held low, any running wave is cancelled and start strobes are ignored.
- R8: In capture mode, every rising or falling edge of `pin_in` loads `sync_ts`. It loads the `time_now` value present SYNC_STAGES clock edges after the edge on which the new level is first sampled (2 edges with the default settings). A later edge overwrites an earlier capture.
- R9: While `capture_mode` is 0, edges on `pin_in` leave `sync_ts` unchanged.
- R10: The half-period is latched when the start strobe is accepted. Changing `half_per` while the wave runs does not alter the edge spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; `time_now` advances in this domain |
| rst_n | input | 1 | Active-low synchronous reset |
| time_now | input | TS_W | Live value of the time counter |
| start_time | input | TS_W | Scheduled time of the first rising edge |
| half_per | input | HP_W | Ticks between consecutive pin edges |
| start_cmd | input | 1 | One-cycle strobe that arms the wave |
| stop_cmd | input | 1 | One-cycle strobe that halts the wave |
| capture_mode | input | 1 | 1 = pin is a capture input, 0 = pin drives the wave |
| pin_in | input | 1 | Asynchronous level from the pin when used as input |
| pin_out | output | 1 | Wave level to drive onto the pin |
| pin_oe | output | 1 | Pin driver enable |
| sync_ts | output | TS_W | Counter value latched at the most recent input edge |

## Verification
The wave is run with half-periods of 1, 3 and 7 and with several lead times before the start. A half-period of 1 shows whether the edge accumulator keeps up on every tick. The odd spacings show whether the phase is counted from the scheduled edge rather than from the compare cycle. Start strobes with a start time equal to the current time, in the past, with a zero half-period, issued together with stop, or issued in capture mode must all leave the pin low. This distinguishes each of the rejection paths from one another. Single and back-to-back input edges show the synchronizer latency and whether the latest capture overwrites the earlier one.

// File: rtl/spo_pkg.sv
package spo_pkg;
   typedef enum logic [1:0] {
      SCH_IDLE  = 2'd0,
      SCH_ARMED = 2'd1,
      SCH_RUN   = 2'd2
   } sch_state_e;
endpackage

// File: rtl/spo_wave_sched.sv
module spo_wave_sched
   import spo_pkg::*;
#(
   parameter int TS_W = 64,
   parameter int HP_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [TS_W-1:0] time_now,
   input  logic [TS_W-1:0] start_time,
   input  logic [HP_W-1:0] half_per,
   input  logic            start_cmd,
   input  logic            stop_cmd,
   input  logic            hold,
   output logic            pin_q,
   output logic            active
);
   localparam int PAD_W = TS_W - HP_W;

   sch_state_e      state_q;
   logic [TS_W-1:0] next_edge_q;
   logic [HP_W-1:0] hp_q;
   logic            start_ok;
   logic            edge_due;
   logic [TS_W-1:0] hp_ext;

   // a start is accepted only with a nonzero spacing and a future time
   assign start_ok = start_cmd && (half_per != '0) && (start_time > time_now);
   assign edge_due = (state_q != SCH_IDLE) && (time_now >= next_edge_q);

   generate
      if (PAD_W > 0) begin : g_pad
         assign hp_ext = {{PAD_W{1'b0}}, hp_q};
      end else begin : g_nopad
         assign hp_ext = hp_q;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= SCH_IDLE;
         next_edge_q <= '0;
         hp_q        <= '0;
         pin_q       <= 1'b0;
      end else if (hold || stop_cmd) begin
         state_q <= SCH_IDLE;
         pin_q   <= 1'b0;
      end else if (start_ok) begin
         state_q     <= SCH_ARMED;
         next_edge_q <= start_time;
         hp_q        <= half_per;
         pin_q       <= 1'b0;
      end else if (edge_due) begin
         state_q     <= SCH_RUN;
         pin_q       <= ~pin_q;
         next_edge_q <= next_edge_q + hp_ext;
      end
   end

   assign active = (state_q != SCH_IDLE);
endmodule

// File: rtl/spo_edge_capture.sv
module spo_edge_capture #(
   parameter int TS_W        = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            pin_in,
   input  logic            enable,
   input  logic [TS_W-1:0] time_now,
   output logic [TS_W-1:0] sync_ts
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   last_q;
   logic                   level;
   logic                   toggled;

   generate
      for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
         if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) sync_q[g] <= 1'b0;
               else        sync_q[g] <= pin_in;
            end
         end else begin : g_chain
            always_ff @(posedge clk) begin
               if (!rst_n) sync_q[g] <= 1'b0;
               else        sync_q[g] <= sync_q[g-1];
            end
         end
      end
   endgenerate

   assign level   = sync_q[SYNC_STAGES-1];
   assign toggled = level ^ last_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_q  <= 1'b0;
         sync_ts <= '0;
      end else begin
         last_q <= level;
         if (enable && toggled) sync_ts <= time_now;
      end
   end
endmodule

// File: rtl/sched_pin_wave.sv
module sched_pin_wave #(
   parameter int TS_W        = 64,
   parameter int HP_W        = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [TS_W-1:0] time_now,
   input  logic [TS_W-1:0] start_time,
   input  logic [HP_W-1:0] half_per,
   input  logic            start_cmd,
   input  logic            stop_cmd,
   input  logic            capture_mode,
   input  logic            pin_in,
   output logic            pin_out,
   output logic            pin_oe,
   output logic [TS_W-1:0] sync_ts
);
   generate
      if (HP_W > TS_W) begin : g_bad_width
         $error("half-period width must not exceed time width");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("synchronizer needs at least two stages");
      end
   endgenerate

   logic sched_active;

   spo_wave_sched #(
      .TS_W(TS_W),
      .HP_W(HP_W)
   ) u_sched (
      .clk       (clk),
      .rst_n     (rst_n),
      .time_now  (time_now),
      .start_time(start_time),
      .half_per  (half_per),
      .start_cmd (start_cmd),
      .stop_cmd  (stop_cmd),
      .hold      (capture_mode),
      .pin_q     (pin_out),
      .active    (sched_active)
   );

   spo_edge_capture #(
      .TS_W       (TS_W),
      .SYNC_STAGES(SYNC_STAGES)
   ) u_capt (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_in  (pin_in),
      .enable  (capture_mode),
      .time_now(time_now),
      .sync_ts (sync_ts)
   );

   assign pin_oe = ~capture_mode;
endmodule

// File: rtl/spo_checker.sv
module spo_checker #(
   parameter int TS_W = 64,
   parameter int HP_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic [TS_W-1:0] time_now,
   input logic [TS_W-1:0] start_time,
   input logic [HP_W-1:0] half_per,
   input logic            start_cmd,
   input logic            stop_cmd,
   input logic            capture_mode,
   input logic            pin_out,
   input logic [TS_W-1:0] sync_ts,
   input logic            active
);
   // R6
   stop_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_cmd |=> (!pin_out && !active));

   // R7
   capture_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      capture_mode |=> (!pin_out && !active));

   // R9
   no_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !capture_mode |=> $stable(sync_ts));

   // R3
   zero_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && start_cmd && half_per == '0) |=> !active);

   // R2
   past_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && start_cmd && start_time <= time_now) |=> !active);

   // R4
   idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> !pin_out);
endmodule

bind sched_pin_wave spo_checker #(
   .TS_W(TS_W),
   .HP_W(HP_W)
) u_spo_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .time_now    (time_now),
   .start_time  (start_time),
   .half_per    (half_per),
   .start_cmd   (start_cmd),
   .stop_cmd    (stop_cmd),
   .capture_mode(capture_mode),
   .pin_out     (pin_out),
   .sync_ts     (sync_ts),
   .active      (sched_active)
);

// File: tb/sched_pin_wave_bench.sv
`timescale 1ns/1ps
module sched_pin_wave_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] time_now = '0;
   logic [63:0] start_time = '0;
   logic [31:0] half_per = '0;
   logic        start_cmd = 1'b0;
   logic        stop_cmd = 1'b0;
   logic        capture_mode = 1'b0;
   logic        pin_in = 1'b0;
   logic        pin_out;
   logic        pin_oe;
   logic [63:0] sync_ts;

   int errors = 0;
   int checks = 0;

   always #5 clk = ~clk;

   sched_pin_wave u_sched_pin_wave (
      .clk(clk), .rst_n(rst_n), .time_now(time_now), .start_time(start_time),
      .half_per(half_per), .start_cmd(start_cmd), .stop_cmd(stop_cmd),
      .capture_mode(capture_mode), .pin_in(pin_in), .pin_out(pin_out),
      .pin_oe(pin_oe), .sync_ts(sync_ts)
   );

   // free-running tick counter, one tick per clock
   initial forever begin
      @(negedge clk);
      time_now <= time_now + 64'd1;
   end

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // move to a point just after a falling edge
   task automatic pt();
      @(negedge clk);
      #1;
   endtask

   function automatic logic exp_pin(logic [63:0] v, logic [63:0] s, logic [63:0] h);
      logic [63:0] k;
      if (v < s) return 1'b0;
      k = (v - s) / h + 64'd1;
      return k[0];
   endfunction

   task automatic do_stop();
      stop_cmd = 1'b1;
      pt();
      stop_cmd = 1'b0;
      pt();
   endtask

   task automatic t_reset();
      chk("R1 pin_out", {63'd0, pin_out}, 64'd0);
      chk("R1 sync_ts", sync_ts, 64'd0);
      chk("R1 pin_oe", {63'd0, pin_oe}, 64'd1);
   endtask

   // start a wave D ticks ahead with spacing H; compare N cycles
   task automatic t_wave(string req, int d, int h, int n, logic alter_hp);
      logic [63:0] s;
      s = time_now + 64'(d);
      start_time = s;
      half_per   = 32'(h);
      start_cmd  = 1'b1;
      pt();
      start_cmd = 1'b0;
      if (alter_hp) half_per = 32'(h + 5);
      for (int i = 0; i < n; i++) begin
         chk(req, {63'd0, pin_out}, {63'd0, exp_pin(time_now - 64'd1, s, 64'(h))});
         pt();
      end
      half_per = 32'(h);
      do_stop();
   endtask

   task automatic t_rejects();
      // start time equal to the sampled time (R2)
      start_time = time_now;
      half_per   = 32'd2;
      start_cmd  = 1'b1;
      pt();
      start_cmd = 1'b0;
      for (int i = 0; i < 8; i++) begin
         chk("R2 equal start", {63'd0, pin_out}, 64'd0);
         pt();
      end
      // start time in the past (R2)
      start_time = time_now - 64'd5;
      start_cmd  = 1'b1;
      pt();
      start_cmd = 1'b0;
      for (int i = 0; i < 8; i++) begin
         chk("R2 past start", {63'd0, pin_out}, 64'd0);
         pt();
      end
      // zero half-period (R3)
      start_time = time_now + 64'd2;
      half_per   = 32'd0;
      start_cmd  = 1'b1;
      pt();
      start_cmd = 1'b0;
      for (int i = 0; i < 8; i++) begin
         chk("R3 zero spacing", {63'd0, pin_out}, 64'd0);
         pt();
      end
      // start and stop together (R6)
      start_time = time_now + 64'd2;
      half_per   = 32'd2;
      start_cmd  = 1'b1;
      stop_cmd   = 1'b1;
      pt();
      start_cmd = 1'b0;
      stop_cmd  = 1'b0;
      for (int i = 0; i < 8; i++) begin
         chk("R6 stop wins", {63'd0, pin_out}, 64'd0);
         pt();
      end
   endtask

   task automatic t_stop();
      logic [63:0] s;
      s = time_now + 64'd3;
      start_time = s;
      half_per   = 32'd4;
      start_cmd  = 1'b1;
      pt();
      start_cmd = 1'b0;
      // run until the pin is high, then stop
      for (int i = 0; i < 5; i++) pt();
      chk("R4 running high", {63'd0, pin_out}, 64'd1);
      do_stop();
      for (int i = 0; i < 10; i++) begin
         chk("R6 halted low", {63'd0, pin_out}, 64'd0);
         pt();
      end
   endtask

   task automatic t_capture();
      logic [63:0] t;
      capture_mode = 1'b1;
      pt();
      chk("R7 driver off", {63'd0, pin_oe}, 64'd0);
      // start attempt while capturing is dropped
      start_time = time_now + 64'd2;
      half_per   = 32'd1;
      start_cmd  = 1'b1;
      pt();
      start_cmd = 1'b0;
      pt();
      pt();
      // rising edge
      t = time_now;
      pin_in = 1'b1;
      pt(); pt(); pt();
      chk("R8 rise capture", sync_ts, t + 64'd2);
      // falling edge
      t = time_now;
      pin_in = 1'b0;
      pt(); pt(); pt();
      chk("R8 fall capture", sync_ts, t + 64'd2);
      // back-to-back edges: second overwrites
      t = time_now;
      pin_in = 1'b1;
      pt();
      pin_in = 1'b0;
      pt(); pt(); pt();
      chk("R8 overwrite", sync_ts, t + 64'd3);
      capture_mode = 1'b0;
      pt();
      chk("R7 driver back", {63'd0, pin_oe}, 64'd1);
      for (int i = 0; i < 6; i++) begin
         chk("R7 start dropped", {63'd0, pin_out}, 64'd0);
         pt();
      end
   endtask

   task automatic t_ignore_input();
      logic [63:0] held;
      held = sync_ts;
      pin_in = 1'b1;
      pt(); pt(); pt();
      pin_in = 1'b0;
      pt(); pt(); pt();
      chk("R9 no capture", sync_ts, held);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      repeat (3) pt();
      rst_n = 1'b1;
      pt();
      t_reset();
      t_wave("R4 R5 h3", 5, 3, 30, 1'b0);
      t_wave("R5 h1", 2, 1, 20, 1'b0);
      t_wave("R5 h7", 9, 7, 50, 1'b0);
      t_wave("R10 latched spacing", 4, 3, 30, 1'b1);
      t_rejects();
      t_stop();
      t_capture();
      t_ignore_input();
      finish_run();
   end
endmodule